// File: doc/BRIEF.md
# Forwarding Address Lookup Engine

This block keeps a table of forwarding entries, each pairing a 48-bit station address with forwarding fields. Software reaches the table indirectly, through a small register window. It loads a staging window of three 32-bit words and then names the target slot in a table-control register. A second port takes a destination address and an ingress port, and returns the set of egress ports for that frame. The returned set is always filtered by a 2-bit forwarding state held for each port.

A lookup walks the table from slot 0 upward, reading one slot per cycle, and stops at the first slot that holds an address entry whose address matches the key. The match yields either one egress port or, for a group address, a port mask. If nothing matches, the frame floods to every port except the one it arrived on. Bypass mode and a disabled engine both answer in a single cycle. A table clear wipes every slot at one slot per cycle, and register writes and lookups are shut out while it runs.

The controller is a five-state machine. `ST_IDLE` accepts register writes and lookups. `ST_FETCH` copies one slot into the window, one cycle after a read request. `ST_CLEAR` zeroes slot after slot and returns to idle after the last one. `ST_SCAN` issues a slot read every cycle and compares the slot fetched in the previous cycle. `ST_DONE` presents the result for one cycle. The transitions are: idle to clear on a clear write; idle to fetch on a table-read write; idle to scan on a lookup when the engine is enabled and not in bypass; idle to done on a lookup when the engine is disabled or in bypass; fetch to idle; clear to idle after the final slot; scan to done on a hit or after the final slot misses; done to idle.

Top module: `fwd_lookup_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0 and every register reads 0: control at 0x00, table control at 0x04, window words at 0x10/0x14/0x18, and port state p at 0x20+4p.
- R2: A write to 0x04 with bit 31 set stores the window into slot bits[IW-1:0]. A write with bit 31 clear loads that slot into the window, and the window is readable two cycles after the write. Word 0x18 holds entry bits 31:0, word 0x14 holds bits 63:32, and word 0x10 holds the bits above 63 in its low bits.
- R3: Entry layout: bits 47:0 hold the address, with the first byte on the wire in 47:40, so bit 40 is the group flag. Bits 61:60 hold the kind (0 free, 1 address, 2 VLAN, 3 VLAN+address). An individual-address entry holds its egress port at 67:66, blocked at 65 and secure at 64. A group entry holds its port mask from bit 66 up.
- R4: A lookup returns the lowest-numbered slot of kind 1 or 3 whose address equals the key; slots of kind 0 and 2 never match. For a hit in slot k, `res_valid` rises k+3 cycles after the acceptance cycle. For a miss it rises DEPTH+2 cycles after, and it lasts one cycle.
- R5: A hit on an individual address returns the one-hot mask of the entry's port. A hit on a group address returns the entry's mask. `res_hit` is 1 in both cases.
- R6: A miss returns `res_hit`=0 and a mask of all ports except the ingress port `lk_src`.
- R7: Ports whose state (bits 1:0 of their state register) is not 3 (forwarding) are cleared from every hit or miss result. The states are 0 disabled, 1 blocking and 2 learning.
- R8: With control bit 31 (enable) and bit 4 (bypass) set, every lookup returns mask 1 (port 0 only) and `res_hit`=0 one cycle after acceptance, whatever the port states.
- R9: With control bit 31 clear, a lookup returns mask 0 and `res_hit`=0 one cycle after acceptance. Control bit 2 (VLAN aware) is stored and read back but does not change any result.
- R10: A control write with bit 30 set zeroes all DEPTH slots and holds `busy` high for exactly DEPTH cycles. Register writes and lookups presented during that time have no effect, and bit 30 reads back 0.
- R11: A lookup is accepted only in the idle state. A lookup presented in the same cycle as a table-control write or a clear write is dropped and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| lk_valid | input | 1 | Lookup request |
| lk_mac | input | 48 | Destination address to look up |
| lk_src | input | SW | Ingress port of the frame |
| busy | output | 1 | Engine not idle; lookups and writes are not taken |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Result came from a table entry |
| res_mask | output | NPORTS | Egress port mask after state filtering |

## Verification
The bench plants decoys ahead of a real entry: a VLAN-only slot and a free slot carrying the same address, followed by a second matching slot after it. A scan that ignored the entry kind, or kept the last match instead of the first, would return the wrong port. Latency is measured for every lookup, so a compare pipeline that lags by a cycle or stops one slot early shows up as a count error. Floods are tried from each ingress port under several port-state mixes; a design that forgot to drop the ingress port, or filtered on the wrong state code, would return extra bits. A clear is issued with a state write and a lookup inside it, and its busy window is counted; a design that let either through, or cleared one slot short, would be caught by a readback or the count.

// File: rtl/fle_pkg.sv
package fle_pkg;

    localparam int MAC_W = 48;

    // entry field positions
    localparam int KIND_LO  = 60;
    localparam int GROUP_BT = 40;
    localparam int HI_LO    = 66;

    // register byte offsets
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_TBL  = 8'h04;
    localparam logic [7:0] OFS_W0   = 8'h10;
    localparam logic [7:0] OFS_W1   = 8'h14;
    localparam logic [7:0] OFS_W2   = 8'h18;
    localparam logic [7:0] OFS_PST  = 8'h20;

    localparam logic [1:0] PST_FWD = 2'd3;

    typedef enum logic [1:0] {
        KIND_FREE  = 2'd0,
        KIND_ADDR  = 2'd1,
        KIND_VLAN  = 2'd2,
        KIND_VADDR = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CLEAR,
        ST_SCAN,
        ST_DONE
    } fle_state_e;

endpackage

// File: rtl/fle_table_ram.sv
module fle_table_ram #(
    parameter int DEPTH = 1024,
    parameter int W     = 69,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[addr] <= wdata;
        end
        rdata <= slots[addr];
    end

endmodule

// File: rtl/fle_entry_match.sv
module fle_entry_match
    import fle_pkg::*;
#(
    parameter int NPORTS = 3,
    localparam int MW    = (NPORTS > 2) ? NPORTS : 2
) (
    input  logic [MAC_W-1:0]  key,
    input  logic [MAC_W-1:0]  ent_mac,
    input  logic [1:0]        ent_kind,
    input  logic [MW-1:0]     ent_hi,
    output logic              hit,
    output logic [NPORTS-1:0] mask
);

    logic              is_addr;
    logic              is_group;
    logic [1:0]        port_num;
    logic [NPORTS-1:0] one_hot;

    assign is_addr  = (ent_kind == KIND_ADDR) || (ent_kind == KIND_VADDR);
    assign is_group = ent_mac[GROUP_BT];
    assign port_num = ent_hi[1:0];
    assign hit      = is_addr && (ent_mac == key);

    for (genvar p = 0; p < NPORTS; p++) begin : g_oh
        assign one_hot[p] = (port_num == 2'(p));
    end

    assign mask = is_group ? ent_hi[NPORTS-1:0] : one_hot;

endmodule

// File: rtl/fle_port_gate.sv
module fle_port_gate
    import fle_pkg::*;
#(
    parameter int NPORTS = 3
) (
    input  logic [2*NPORTS-1:0] pst,
    input  logic [NPORTS-1:0]   raw,
    output logic [NPORTS-1:0]   gated
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_gate
        assign gated[p] = raw[p] && (pst[2*p +: 2] == PST_FWD);
    end

endmodule

// File: rtl/fwd_lookup_engine.sv
module fwd_lookup_engine
    import fle_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int NPORTS = 3,
    localparam int SW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              lk_valid,
    input  logic [47:0]       lk_mac,
    input  logic [SW-1:0]     lk_src,
    output logic              busy,
    output logic              res_valid,
    output logic              res_hit,
    output logic [NPORTS-1:0] res_mask
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int MW = (NPORTS > 2) ? NPORTS : 2;
    localparam int EW = HI_LO + MW;
    localparam int TW = EW - 64;
    localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
    localparam logic [NPORTS-1:0] HOST_MASK = NPORTS'(1);

    fle_state_e state, state_nx;

    logic                ctrl_en, ctrl_byp, ctrl_vlan;
    logic [IW-1:0]       tbl_idx;
    logic [EW-1:0]       win;
    logic [2*NPORTS-1:0] pst;

    logic [IW-1:0]       scan_idx;
    logic                scan_go, pend_v, pend_last;
    logic [IW-1:0]       clr_idx;
    logic [MAC_W-1:0]    key_q;
    logic [SW-1:0]       src_q;
    logic                hit_q;
    logic [NPORTS-1:0]   mask_q;

    // register write decode
    logic              wr_ok, wr_ctrl, wr_tbl, wr_w0, wr_w1, wr_w2;
    logic [NPORTS-1:0] wr_pst;
    logic              start_clear, tbl_store, tbl_fetch, lk_take;

    assign wr_ok       = reg_wr && (state == ST_IDLE);
    assign wr_ctrl     = wr_ok && (reg_addr == OFS_CTRL);
    assign wr_tbl      = wr_ok && (reg_addr == OFS_TBL);
    assign wr_w0       = wr_ok && (reg_addr == OFS_W0);
    assign wr_w1       = wr_ok && (reg_addr == OFS_W1);
    assign wr_w2       = wr_ok && (reg_addr == OFS_W2);
    assign start_clear = wr_ctrl && reg_wdata[30];
    assign tbl_store   = wr_tbl && reg_wdata[31];
    assign tbl_fetch   = wr_tbl && !reg_wdata[31];
    assign lk_take     = (state == ST_IDLE) && lk_valid && !wr_tbl && !start_clear;

    for (genvar p = 0; p < NPORTS; p++) begin : g_pdec
        assign wr_pst[p] = wr_ok && (reg_addr == OFS_PST + 8'(4 * p));
    end

    // table port arbitration
    logic          ram_we;
    logic [IW-1:0] ram_addr;
    logic [EW-1:0] ram_wdata, ram_rdata;

    always_comb begin
        ram_we    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                ram_we    = tbl_store;
                ram_addr  = reg_wdata[IW-1:0];
                ram_wdata = win;
            end
            ST_CLEAR: begin
                ram_we   = 1'b1;
                ram_addr = clr_idx;
            end
            ST_SCAN:  ram_addr = scan_idx;
            ST_FETCH: ram_addr = tbl_idx;
            ST_DONE:  ram_addr = '0;
            default:  ram_addr = '0;
        endcase
    end

    fle_table_ram #(.DEPTH(DEPTH), .W(EW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // compare stage
    logic              m_hit;
    logic [NPORTS-1:0] m_mask, miss_mask, raw_sel, gated;

    fle_entry_match #(.NPORTS(NPORTS)) u_match (
        .key      (key_q),
        .ent_mac  (ram_rdata[MAC_W-1:0]),
        .ent_kind (ram_rdata[KIND_LO +: 2]),
        .ent_hi   (ram_rdata[EW-1:HI_LO]),
        .hit      (m_hit),
        .mask     (m_mask)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_miss
        assign miss_mask[p] = (src_q != SW'(p));
    end

    assign raw_sel = m_hit ? m_mask : miss_mask;

    fle_port_gate #(.NPORTS(NPORTS)) u_gate (
        .pst   (pst),
        .raw   (raw_sel),
        .gated (gated)
    );

    logic scan_end;
    assign scan_end = pend_v && (m_hit || pend_last);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start_clear)    state_nx = ST_CLEAR;
                else if (tbl_fetch) state_nx = ST_FETCH;
                else if (lk_take)   state_nx = (!ctrl_en || ctrl_byp) ? ST_DONE : ST_SCAN;
            end
            ST_FETCH: state_nx = ST_IDLE;
            ST_CLEAR: if (clr_idx == LAST_IDX) state_nx = ST_IDLE;
            ST_SCAN:  if (scan_end) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // configuration and window registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_byp  <= 1'b0;
            ctrl_vlan <= 1'b0;
            tbl_idx   <= '0;
            win       <= '0;
            pst       <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en   <= reg_wdata[31];
                ctrl_byp  <= reg_wdata[4];
                ctrl_vlan <= reg_wdata[2];
            end
            if (wr_tbl) tbl_idx <= reg_wdata[IW-1:0];
            if (wr_w0)  win[EW-1:64] <= reg_wdata[TW-1:0];
            if (wr_w1)  win[63:32]   <= reg_wdata;
            if (wr_w2)  win[31:0]    <= reg_wdata;
            if (state == ST_FETCH) win <= ram_rdata;
            for (int p = 0; p < NPORTS; p++) begin
                if (wr_pst[p]) pst[2*p +: 2] <= reg_wdata[1:0];
            end
        end
    end

    // scan, clear and result datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx  <= '0;
            scan_go   <= 1'b0;
            pend_v    <= 1'b0;
            pend_last <= 1'b0;
            clr_idx   <= '0;
            key_q     <= '0;
            src_q     <= '0;
            hit_q     <= 1'b0;
            mask_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_clear) clr_idx <= '0;
                    if (lk_take && !start_clear && !tbl_fetch) begin
                        key_q    <= lk_mac;
                        src_q    <= lk_src;
                        scan_idx <= '0;
                        scan_go  <= 1'b1;
                        pend_v   <= 1'b0;
                        hit_q    <= 1'b0;
                        mask_q   <= ctrl_en ? HOST_MASK : '0;
                    end
                end
                ST_CLEAR: clr_idx <= clr_idx + 1'b1;
                ST_SCAN: begin
                    pend_v    <= scan_go;
                    pend_last <= (scan_idx == LAST_IDX);
                    if (scan_go) begin
                        if (scan_idx == LAST_IDX) scan_go  <= 1'b0;
                        else                      scan_idx <= scan_idx + 1'b1;
                    end
                    if (scan_end) begin
                        hit_q  <= m_hit;
                        mask_q <= gated;
                        pend_v <= 1'b0;
                    end
                end
                ST_FETCH: clr_idx <= clr_idx;
                ST_DONE:  scan_go <= 1'b0;
                default:  scan_go <= 1'b0;
            endcase
        end
    end

    // register read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: reg_rdata = {ctrl_en, 26'b0, ctrl_byp, 1'b0, ctrl_vlan, 2'b0};
            OFS_TBL:  reg_rdata = {{(32-IW){1'b0}}, tbl_idx};
            OFS_W0:   reg_rdata = {{(32-TW){1'b0}}, win[EW-1:64]};
            OFS_W1:   reg_rdata = win[63:32];
            OFS_W2:   reg_rdata = win[31:0];
            default: begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (reg_addr == OFS_PST + 8'(4 * p)) reg_rdata = {30'b0, pst[2*p +: 2]};
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        res_valid = (state == ST_DONE);
        res_hit   = hit_q;
        res_mask  = mask_q;
    end

endmodule

// File: rtl/fle_checker.sv
module fle_checker #(
    parameter int NPORTS = 3,
    parameter int SW     = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic                lk_valid,
    input logic                lk_take,
    input logic [SW-1:0]       lk_src,
    input logic                busy,
    input logic                res_valid,
    input logic                res_hit,
    input logic [NPORTS-1:0]   res_mask,
    input logic                ctrl_en,
    input logic                ctrl_byp,
    input logic [2*NPORTS-1:0] pst
);

    logic          cap_en, cap_byp;
    logic [SW-1:0] cap_src;
    logic [NPORTS-1:0] fwd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_en  <= 1'b0;
            cap_byp <= 1'b0;
            cap_src <= '0;
        end else if (lk_take) begin
            cap_en  <= ctrl_en;
            cap_byp <= ctrl_byp;
            cap_src <= lk_src;
        end
    end

    always_comb begin
        for (int p = 0; p < NPORTS; p++) fwd[p] = (pst[2*p +: 2] == 2'd3);
    end

    assert_res_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !busy && !reg_wr) |=> busy);

    assert_gate_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_en && !cap_byp) |-> ((res_mask & ~fwd) == '0));

    assert_miss_no_ingress_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_en && !cap_byp && !res_hit) |-> !res_mask[cap_src]);

    assert_bypass_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_en && cap_byp) |-> (res_mask == NPORTS'(1) && !res_hit));

    assert_disabled_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !cap_en) |-> (res_mask == '0 && !res_hit));

endmodule

bind fwd_lookup_engine fle_checker #(.NPORTS(NPORTS), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .lk_valid  (lk_valid),
    .lk_take   (lk_take),
    .lk_src    (lk_src),
    .busy      (busy),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_mask  (res_mask),
    .ctrl_en   (ctrl_en),
    .ctrl_byp  (ctrl_byp),
    .pst       (pst)
);

// File: tb/sim_fwd_lookup_engine.sv
module sim_fwd_lookup_engine;

    localparam int DEPTH  = 16;
    localparam int NPORTS = 3;
    localparam int SW     = 2;

    localparam logic [7:0] A_CTRL = 8'h00, A_TBL = 8'h04, A_W0 = 8'h10,
                           A_W1 = 8'h14, A_W2 = 8'h18, A_PST = 8'h20;

    localparam logic [47:0] MAC_A  = 48'h00_11_22_33_44_55;
    localparam logic [47:0] MAC_M  = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] MAC_BC = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] MAC_C  = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [47:0] MAC_D  = 48'h00_DE_AD_BE_EF_00;

    // vector: mac[61:14] src[13:12] hit[11] mask[10:8] latency[7:0]
    localparam logic [61:0] VEC [7] = '{
        {MAC_A,  2'd0, 1'b1, 3'b100, 8'd5},
        {MAC_M,  2'd0, 1'b1, 3'b110, 8'd7},
        {MAC_BC, 2'd1, 1'b1, 3'b111, 8'd8},
        {MAC_C,  2'd0, 1'b1, 3'b010, 8'd9},
        {MAC_D,  2'd1, 1'b0, 3'b101, 8'd18},
        {MAC_D,  2'd0, 1'b0, 3'b110, 8'd18},
        {MAC_D,  2'd2, 1'b0, 3'b011, 8'd18}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              lk_valid = 1'b0;
    logic [47:0]       lk_mac = '0;
    logic [SW-1:0]     lk_src = '0;
    logic              busy, res_valid, res_hit;
    logic [NPORTS-1:0] res_mask;

    fwd_lookup_engine #(.DEPTH(DEPTH), .NPORTS(NPORTS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_mac(lk_mac), .lk_src(lk_src), .busy(busy), .res_valid(res_valid),
        .res_hit(res_hit), .res_mask(res_mask)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [68:0] mk(input logic [1:0] kind, input logic [47:0] mac,
                                       input logic [4:0] hi);
        return {hi, 2'b00, kind, 12'b0, mac};
    endfunction

    task automatic tbl_put(input int idx, input logic [68:0] e);
        wr(A_W0, {27'b0, e[68:64]});
        wr(A_W1, e[63:32]);
        wr(A_W2, e[31:0]);
        wr(A_TBL, 32'h8000_0000 | 32'(idx));
    endtask

    task automatic tbl_get(input int idx, output logic [31:0] w0, output logic [31:0] w1,
                           output logic [31:0] w2);
        wr(A_TBL, 32'(idx));
        @(negedge clk);
        rd(A_W0, w0); rd(A_W1, w1); rd(A_W2, w2);
    endtask

    task automatic lookup(input logic [47:0] mac, input logic [SW-1:0] src,
                          output logic hit, output logic [NPORTS-1:0] mask, output int lat);
        @(negedge clk);
        lk_valid = 1'b1; lk_mac = mac; lk_src = src;
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 1;
        while (!res_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        hit = res_hit; mask = res_mask;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d, w0, w1, w2;
        logic hit;
        logic [NPORTS-1:0] mask;
        logic [68:0] e;
        int lat, cnt, seen;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 res_valid", 64'(res_valid), 64'd0);
        rd(A_CTRL, d); chk("R1 ctrl", 64'(d), 64'd0);
        rd(A_TBL, d);  chk("R1 tblctl", 64'(d), 64'd0);
        rd(A_W0, d);   chk("R1 word0", 64'(d), 64'd0);
        rd(A_W2, d);   chk("R1 word2", 64'(d), 64'd0);
        rd(A_PST + 8'd8, d); chk("R1 port2 state", 64'(d), 64'd0);

        // R10: clear, with a state write and a lookup inside the busy window
        wr(A_CTRL, 32'hC000_0000);
        cnt = 0; seen = 0;
        reg_wr = 1'b1; reg_addr = A_PST + 8'd8; reg_wdata = 32'd3;
        lk_valid = 1'b1; lk_mac = MAC_A; lk_src = 2'd0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
            reg_wr = 1'b0; lk_valid = 1'b0;
            if (res_valid) seen++;
        end
        repeat (5) begin @(negedge clk); if (res_valid) seen++; end
        chk("R10 busy cycles", 64'(cnt), 64'(DEPTH));
        chk("R10 lookup during clear ignored", 64'(seen), 64'd0);
        rd(A_PST + 8'd8, d); chk("R10 write during clear ignored", 64'(d), 64'd0);
        rd(A_CTRL, d); chk("R10 clear bit self-clears", 64'(d), 64'h8000_0000);

        // populate: decoys first, then real entries (R3 layout)
        tbl_put(5, mk(2'd1, MAC_D, 5'b00100));
        tbl_get(5, w0, w1, w2);
        chk("R2 word0 before clear", 64'(w0), 64'h4);
        wr(A_CTRL, 32'hC000_0000);
        while (busy) @(negedge clk);
        tbl_get(5, w0, w1, w2);
        chk("R10 slot zeroed", {w0, w2}, 64'd0);
        chk("R10 slot zeroed hi", 64'(w1), 64'd0);

        tbl_put(0, mk(2'd2, MAC_A, 5'b00000));
        tbl_put(1, mk(2'd0, MAC_A, 5'b00100));
        tbl_put(2, mk(2'd1, MAC_A, 5'b01001));
        tbl_put(3, mk(2'd3, MAC_A, 5'b00100));
        tbl_put(4, mk(2'd1, MAC_M, 5'b11000));
        tbl_put(5, mk(2'd1, MAC_BC, 5'b11100));
        tbl_put(6, mk(2'd3, MAC_C, 5'b00110));
        for (int p = 0; p < NPORTS; p++) wr(A_PST + 8'(4 * p), 32'd3);

        // R2: readback and word order
        e = mk(2'd3, MAC_C, 5'b00110);
        tbl_get(6, w0, w1, w2);
        chk("R2 word2 bits31:0", 64'(w2), 64'(e[31:0]));
        chk("R2 word1 bits63:32", 64'(w1), 64'(e[63:32]));
        chk("R2 word0 top bits", 64'(w0), 64'(e[68:64]));
        tbl_get(2, w0, w1, w2);
        chk("R3 port and secure bits", 64'(w0), 64'h9);
        chk("R3 kind bits", 64'(w1[29:28]), 64'd1);

        // main vector walk: R4 order/latency, R5 hit masks, R6 flooding
        for (int i = 0; i < 7; i++) begin
            lookup(VEC[i][61:14], VEC[i][13:12], hit, mask, lat);
            chk(VEC[i][11] ? "R5 hit flag" : "R6 hit flag", 64'(hit), 64'(VEC[i][11]));
            chk(VEC[i][11] ? "R5 mask" : "R6 mask", 64'(mask), 64'(VEC[i][10:8]));
            chk("R4 latency", 64'(lat), 64'(VEC[i][7:0]));
        end

        // R7: forwarding-state filter
        wr(A_PST + 8'd4, 32'd2);
        lookup(MAC_BC, 2'd0, hit, mask, lat);
        chk("R7 learning port removed", 64'(mask), 64'b101);
        wr(A_PST + 8'd4, 32'd1);
        wr(A_PST + 8'd8, 32'd0);
        lookup(MAC_D, 2'd1, hit, mask, lat);
        chk("R7 flood filtered", 64'(mask), 64'b001);
        wr(A_PST, 32'd0);
        lookup(MAC_A, 2'd1, hit, mask, lat);
        chk("R7 hit on disabled port", {hit, mask}, {1'b1, 3'b000});

        // R8: bypass ignores table and states
        wr(A_CTRL, 32'h8000_0010);
        lookup(MAC_A, 2'd1, hit, mask, lat);
        chk("R8 bypass result", {hit, mask}, {1'b0, 3'b001});
        chk("R8 bypass latency", 64'(lat), 64'd1);

        // R9: disabled engine, then VLAN bit without effect
        wr(A_CTRL, 32'h0000_0000);
        lookup(MAC_A, 2'd0, hit, mask, lat);
        chk("R9 disabled result", {hit, mask}, {1'b0, 3'b000});
        chk("R9 disabled latency", 64'(lat), 64'd1);
        for (int p = 0; p < NPORTS; p++) wr(A_PST + 8'(4 * p), 32'd3);
        wr(A_CTRL, 32'h8000_0004);
        rd(A_CTRL, d); chk("R9 vlan bit readback", 64'(d), 64'h8000_0004);
        lookup(MAC_M, 2'd0, hit, mask, lat);
        chk("R9 vlan bit no effect", {hit, mask}, {1'b1, 3'b110});
        chk("R9 vlan bit latency", 64'(lat), 64'd7);

        // R11: lookup colliding with a table-control write is dropped
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_TBL; reg_wdata = 32'd4;
        lk_valid = 1'b1; lk_mac = MAC_A; lk_src = 2'd0;
        @(negedge clk);
        reg_wr = 1'b0; lk_valid = 1'b0;
        seen = 0;
        repeat (30) begin @(negedge clk); if (res_valid) seen++; end
        chk("R11 colliding lookup dropped", 64'(seen), 64'd0);
        rd(A_W0, d); chk("R11 table read still served", 64'(d), 64'h18);

        summary();
        $finish;
    end

endmodule